// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is the multiply and divide engine of a 32-bit single-cycle processor that follows the usual register-register encoding: a primary opcode of all zeros selects the register-type group, and a six-bit function field picks the operation. The unit holds the two architectural result registers, HI and LO. It performs signed and unsigned multiplication in a single cycle. It performs signed and unsigned division with an iterative restoring divider, so no full-width combinational divider sits in the clock path.

The processor presents the decoded instruction fields, the two source operand values and the destination register index every cycle. While a divide is in progress, the unit raises a stall output. The processor holds the same instruction on the inputs until the stall drops. HI and LO take the divide result at the clock edge where the processor moves on.

Two move instructions copy HI or LO into the register file. For these, the unit drives a write port made of an enable, a register index and a data word. A destination index of zero suppresses the write.

Top module: `hilo_muldiv`

## Requirements
- R1: A synchronous active-high reset clears HI and LO to zero, so a move from either one returns 0 after reset.
- R2: With opcode 000000 and function 011000, the signed 64-bit product of the two operands is split across the result registers: the upper 32 bits go to HI and the lower 32 bits go to LO. A move issued in the very next instruction sees the new value.
- R3: With opcode 000000 and function 011001, the operands are treated as unsigned, and the 64-bit product is split the same way: upper half to HI, lower half to LO.
- R4: With opcode 000000 and function 011010, the signed quotient, truncated toward zero, goes to LO, and the remainder goes to HI. The remainder carries the sign of the dividend. Dividing the most negative value by -1 gives LO = 0x80000000 and HI = 0.
- R5: With opcode 000000 and function 011011, the unsigned quotient goes to LO and the unsigned remainder goes to HI.
- R6: A divide keeps the stall output high for 32 consecutive cycles, beginning with the cycle it is first presented. The stall is low in the 33rd cycle, and HI and LO update at the end of that cycle. A multiply never raises the stall.
- R7: A divisor of zero, whether signed or unsigned, still finishes on the normal schedule. It leaves LO = 0xFFFFFFFF and HI equal to the unmodified dividend.
- R8: Function 010000 (with opcode 000000) writes HI, and function 010010 writes LO. The write port carries the destination index and the selected value. When the destination index is 0, the write enable stays low.
- R9: HI and LO keep their values for every other instruction, including a multiply or divide function code under a nonzero opcode. Such instructions never assert the write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode_i | input | 6 | Primary opcode of the current instruction |
| funct_i | input | 6 | Function field of the current instruction |
| rs_val_i | input | 32 | First source operand (dividend / multiplicand) |
| rt_val_i | input | 32 | Second source operand (divisor / multiplier) |
| rd_i | input | 5 | Destination register index |
| busy_o | output | 1 | Stall request; high while a divide has not finished |
| wb_en_o | output | 1 | Register-file write enable for a move from HI/LO |
| wb_idx_o | output | 5 | Register-file write index |
| wb_data_o | output | 32 | Register-file write data |

## Verification
The bench builds the unit with the default data width of 32 and a 5-bit register index. At this width the divider runs its full 32-step loop, so the stall count is checked against the real latency rather than a shortened one. The bench also reaches the 32-bit extremes directly: the most negative dividend divided by -1, and an unsigned multiply of all-ones operands whose product fills all 64 bits. The operand width makes the reference values easy to compute exactly with 64-bit arithmetic in the bench.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    localparam logic [5:0] OP_REGTYPE = 6'b000000;
    localparam logic [5:0] FN_MULT    = 6'b011000;
    localparam logic [5:0] FN_MULTU   = 6'b011001;
    localparam logic [5:0] FN_DIV     = 6'b011010;
    localparam logic [5:0] FN_DIVU    = 6'b011011;
    localparam logic [5:0] FN_MFHI    = 6'b010000;
    localparam logic [5:0] FN_MFLO    = 6'b010010;

    // one-hot operation class plus the signedness of the operands
    typedef struct packed {
        logic mul;
        logic div;
        logic sgn;
        logic mfhi;
        logic mflo;
    } md_dec_t;

endpackage

// File: rtl/md_decode.sv
module md_decode
    import muldiv_pkg::*;
(
    input  logic [5:0] opcode_i,
    input  logic [5:0] funct_i,
    output md_dec_t    dec_o
);

    always_comb begin
        dec_o = '0;
        if (opcode_i == OP_REGTYPE) begin
            case (funct_i)
                FN_MULT:  begin dec_o.mul = 1'b1; dec_o.sgn = 1'b1; end
                FN_MULTU: begin dec_o.mul = 1'b1; end
                FN_DIV:   begin dec_o.div = 1'b1; dec_o.sgn = 1'b1; end
                FN_DIVU:  begin dec_o.div = 1'b1; end
                FN_MFHI:  begin dec_o.mfhi = 1'b1; end
                FN_MFLO:  begin dec_o.mflo = 1'b1; end
                default:  dec_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/md_multiplier.sv
module md_multiplier #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         signed_i,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);

    logic [2*W-1:0] ext_a;
    logic [2*W-1:0] ext_b;
    logic [2*W-1:0] prod;

    // sign-extending to full product width makes the modular product exact
    always_comb begin
        ext_a = {{W{signed_i & a_i[W-1]}}, a_i};
        ext_b = {{W{signed_i & b_i[W-1]}}, b_i};
        prod  = ext_a * ext_b;
        hi_o  = prod[2*W-1:W];
        lo_o  = prod[W-1:0];
    end

endmodule

// File: rtl/md_divider.sv
module md_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         signed_i,
    input  logic [W-1:0] dvd_i,
    input  logic [W-1:0] dvs_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] quot_o,
    output logic [W-1:0] rem_o
);

    localparam int              CNT_W   = $clog2(W);
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(W - 1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [W-1:0]     ONE    = W'(1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     rem;
        logic [W-1:0]     quo;
        logic [W-1:0]     dvs;
        logic             neg_q;
        logic             neg_r;
        logic             dvz;
        logic [W-1:0]     dvd_raw;
    } dstate_t;

    dstate_t s_d, s_q;

    logic [W:0]   shifted;
    logic [W:0]   diff;
    logic         fits;
    logic [W-1:0] rem_nx;
    logic [W-1:0] quo_nx;
    logic         last;

    function automatic logic [W-1:0] magnitude(input logic [W-1:0] v, input logic sg);
        return (sg && v[W-1]) ? (~v + ONE) : v;
    endfunction

    always_comb begin
        // one restoring step on the current partial remainder
        shifted = {s_q.rem, s_q.quo[W-1]};
        diff    = shifted - {1'b0, s_q.dvs};
        fits    = ~diff[W];
        rem_nx  = fits ? diff[W-1:0] : shifted[W-1:0];
        quo_nx  = {s_q.quo[W-2:0], fits};
        last    = s_q.run && (s_q.cnt == LAST);

        s_d = s_q;
        if (!s_q.run) begin
            if (start_i) begin
                s_d.run     = 1'b1;
                s_d.cnt     = '0;
                s_d.rem     = '0;
                s_d.quo     = magnitude(dvd_i, signed_i);
                s_d.dvs     = magnitude(dvs_i, signed_i);
                s_d.neg_q   = signed_i & (dvd_i[W-1] ^ dvs_i[W-1]);
                s_d.neg_r   = signed_i & dvd_i[W-1];
                s_d.dvz     = (dvs_i == '0);
                s_d.dvd_raw = dvd_i;
            end
        end else begin
            s_d.rem = rem_nx;
            s_d.quo = quo_nx;
            s_d.cnt = s_q.cnt + CNT_ONE;
            if (last) s_d.run = 1'b0;
        end

        busy_o = (!s_q.run && start_i) || (s_q.run && !last);
        done_o = last;
        if (s_q.dvz) begin
            quot_o = '1;
            rem_o  = s_q.dvd_raw;
        end else begin
            quot_o = s_q.neg_q ? (~quo_nx + ONE) : quo_nx;
            rem_o  = s_q.neg_r ? (~rem_nx + ONE) : rem_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // R6
    div_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!s_q.run && start_i) |=> s_q.run);

    // R6
    div_count_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q.run && !last) |=> (s_q.run && s_q.cnt == $past(s_q.cnt) + CNT_ONE));

    // R7
    div_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q.run && !last && s_q.dvs == '0) |=> s_q.quo[0]);

endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv
    import muldiv_pkg::*;
#(
    parameter int W      = 32,
    parameter int RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [5:0]        opcode_i,
    input  logic [5:0]        funct_i,
    input  logic [W-1:0]      rs_val_i,
    input  logic [W-1:0]      rt_val_i,
    input  logic [RIDX_W-1:0] rd_i,
    output logic              busy_o,
    output logic              wb_en_o,
    output logic [RIDX_W-1:0] wb_idx_o,
    output logic [W-1:0]      wb_data_o
);

    typedef struct packed {
        logic [W-1:0] hi;
        logic [W-1:0] lo;
    } hilo_t;

    hilo_t        hilo_d, hilo_q;
    md_dec_t      dec;
    logic [W-1:0] mul_hi, mul_lo;
    logic         div_done;
    logic [W-1:0] div_quot, div_rem;

    md_decode u_dec (
        .opcode_i (opcode_i),
        .funct_i  (funct_i),
        .dec_o    (dec)
    );

    md_multiplier #(.W(W)) u_mul (
        .a_i      (rs_val_i),
        .b_i      (rt_val_i),
        .signed_i (dec.sgn),
        .hi_o     (mul_hi),
        .lo_o     (mul_lo)
    );

    md_divider #(.W(W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start_i  (dec.div),
        .signed_i (dec.sgn),
        .dvd_i    (rs_val_i),
        .dvs_i    (rt_val_i),
        .busy_o   (busy_o),
        .done_o   (div_done),
        .quot_o   (div_quot),
        .rem_o    (div_rem)
    );

    always_comb begin
        hilo_d = hilo_q;
        if (dec.mul) begin
            hilo_d.hi = mul_hi;
            hilo_d.lo = mul_lo;
        end else if (div_done) begin
            hilo_d.hi = div_rem;
            hilo_d.lo = div_quot;
        end

        wb_en_o   = (dec.mfhi || dec.mflo) && (rd_i != '0);
        wb_idx_o  = rd_i;
        wb_data_o = dec.mfhi ? hilo_q.hi : hilo_q.lo;
    end

    always_ff @(posedge clk) begin
        if (rst) hilo_q <= '0;
        else     hilo_q <= hilo_d;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (hilo_q == '0));

    // R6
    mul_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
        dec.mul |-> !busy_o);

    // R8
    wb_idx_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en_o |-> (wb_idx_o != '0));

    // R9
    hilo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!dec.mul && !div_done) |=> $stable(hilo_q));

endmodule

// File: tb/sim_hilo_muldiv.sv
`timescale 1ns/1ps
module sim_hilo_muldiv;

    localparam int W = 32;
    localparam logic [5:0] F_MULT  = 6'b011000;
    localparam logic [5:0] F_MULTU = 6'b011001;
    localparam logic [5:0] F_DIV   = 6'b011010;
    localparam logic [5:0] F_DIVU  = 6'b011011;
    localparam logic [5:0] F_MFHI  = 6'b010000;
    localparam logic [5:0] F_MFLO  = 6'b010010;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [5:0]   op  = '0;
    logic [5:0]   fn  = '0;
    logic [W-1:0] a   = '0;
    logic [W-1:0] b   = '0;
    logic [4:0]   rd  = '0;
    logic         busy, wb_en;
    logic [4:0]   wb_idx;
    logic [W-1:0] wb_data;

    always #4 clk = ~clk;

    hilo_muldiv #(.W(W), .RIDX_W(5)) u0 (
        .clk(clk), .rst(rst), .opcode_i(op), .funct_i(fn),
        .rs_val_i(a), .rt_val_i(b), .rd_i(rd),
        .busy_o(busy), .wb_en_o(wb_en), .wb_idx_o(wb_idx), .wb_data_o(wb_data)
    );

    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;
    logic [4:0]   exp_idx_q[$];
    logic [W-1:0] exp_dat_q[$];
    string        exp_tag_q[$];
    logic [W-1:0] m_hi = '0;
    logic [W-1:0] m_lo = '0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor: every writeback seen at the falling edge must match the scoreboard head
    always @(negedge clk) begin
        if (!rst && wb_en) begin
            if (exp_idx_q.size() == 0) begin
                check(1'b0, "R9", "unexpected writeback", {59'b0, wb_idx}, 64'd0);
            end else begin
                automatic logic [4:0]   ei = exp_idx_q.pop_front();
                automatic logic [W-1:0] ed = exp_dat_q.pop_front();
                automatic string        et = exp_tag_q.pop_front();
                check(wb_idx == ei, et, "writeback index", {59'b0, wb_idx}, {59'b0, ei});
                check(wb_data == ed, et, "writeback data", {32'b0, wb_data}, {32'b0, ed});
            end
        end
    end

    // drive after the rising edge, count stall cycles at falling edges
    task automatic issue(input logic [5:0] o, input logic [5:0] f, input logic [W-1:0] x,
                         input logic [W-1:0] y, input logic [4:0] r, input int exp_busy);
        int n = 0;
        @(posedge clk); #1;
        op = o; fn = f; a = x; b = y; rd = r;
        forever begin
            @(negedge clk);
            if (!busy) break;
            n++;
            @(posedge clk); #1;
        end
        // R6: stall length of this instruction
        check(n == exp_busy, "R6", "stall cycles", 64'(n), 64'(exp_busy));
    endtask

    task automatic muldiv(input logic [5:0] f, input logic [W-1:0] x, input logic [W-1:0] y);
        logic signed [63:0] sx, sy, q, r;
        logic [63:0] p;
        sx = {{32{x[W-1]}}, x};
        sy = {{32{y[W-1]}}, y};
        case (f)
            F_MULT:  begin p = sx * sy; m_hi = p[63:32]; m_lo = p[31:0]; end
            F_MULTU: begin p = {32'b0, x} * {32'b0, y}; m_hi = p[63:32]; m_lo = p[31:0]; end
            F_DIV: begin
                if (y == '0) begin m_lo = '1; m_hi = x; end
                else begin q = sx / sy; r = sx % sy; m_lo = q[31:0]; m_hi = r[31:0]; end
            end
            default: begin
                if (y == '0) begin m_lo = '1; m_hi = x; end
                else begin m_lo = x / y; m_hi = x % y; end
            end
        endcase
        issue(6'b000000, f, x, y, 5'd3, (f == F_DIV || f == F_DIVU) ? W : 0);
    endtask

    task automatic move(input bit from_hi, input logic [4:0] r, input string tag);
        if (r != '0) begin
            exp_idx_q.push_back(r);
            exp_dat_q.push_back(from_hi ? m_hi : m_lo);
            exp_tag_q.push_back(tag);
        end
        issue(6'b000000, from_hi ? F_MFHI : F_MFLO, 32'h1234_5678, 32'h9abc_def0, r, 0);
    endtask

    task automatic both(input string tag);
        move(1'b1, 5'd7, tag);
        move(1'b0, 5'd31, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: cleared state
        both("R1");

        // R2: signed multiply
        muldiv(F_MULT, 32'd7, -32'sd3);            both("R2");
        muldiv(F_MULT, 32'h8000_0000, 32'h8000_0000); both("R2");
        muldiv(F_MULT, 32'h7fff_ffff, 32'hffff_ffff); both("R2");

        // R3: unsigned multiply
        muldiv(F_MULTU, 32'hffff_ffff, 32'hffff_ffff); both("R3");
        muldiv(F_MULTU, 32'h8000_0000, 32'd6);          both("R3");

        // R4: signed divide with each sign combination and the overflow case
        muldiv(F_DIV, -32'sd7, 32'd2);             both("R4");
        muldiv(F_DIV, 32'd7, -32'sd2);             both("R4");
        muldiv(F_DIV, -32'sd100, -32'sd7);         both("R4");
        muldiv(F_DIV, 32'h8000_0000, 32'hffff_ffff); both("R4");

        // R5: unsigned divide
        muldiv(F_DIVU, 32'hffff_ffff, 32'd10);     both("R5");
        muldiv(F_DIVU, 32'd5, 32'h8000_0000);      both("R5");

        // R7: divide by zero
        muldiv(F_DIV, -32'sd5, 32'd0);             both("R7");
        muldiv(F_DIVU, 32'd123, 32'd0);            both("R7");

        // R8: destination zero gives no write; back-to-back moves
        move(1'b1, 5'd0, "R8");
        move(1'b0, 5'd0, "R8");
        move(1'b1, 5'd1, "R8");

        // R9: non-muldiv instructions leave HI/LO alone and never write
        issue(6'b000100, F_MULT, 32'd5, 32'd6, 5'd3, 0);
        issue(6'b000100, F_DIV, 32'd5, 32'd6, 5'd3, 0);
        issue(6'b000000, 6'b100000, 32'd5, 32'd6, 5'd3, 0);
        issue(6'b000001, F_MFHI, 32'd0, 32'd0, 5'd4, 0);
        both("R9");

        issue(6'b000000, 6'b000000, 32'd0, 32'd0, 5'd0, 0);
        repeat (2) @(posedge clk);
        // R8: every expected writeback was observed
        check(exp_idx_q.size() == 0, "R8", "missing writebacks", 64'(exp_idx_q.size()), 64'd0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule